// File: doc/BRIEF.md
# Serial LED Output Shifter

This block drives seventeen output levels onto an external serial-in, parallel-out shift register over two wires: serial data and a shift clock. Each frame carries seventeen bits. The most significant bit goes out first, so bit 16 (channel 32) leads and bit 0 (channel 16) trails. A small register port sets the data word, the shift-clock divider, the data-to-clock delay and the operating mode.

The block has two sources. In direct mode, software writes a 17-bit word and that write launches one frame. In PWM mode, the block watches the live levels of seventeen PWM channels. It sends a new frame whenever those levels differ from the last frame that went out. That record of the last frame is cleared to zero by reset. It is also updated by direct frames. So after an all-zero direct frame, PWM mode stays silent until some level becomes non-zero.

A busy flag covers every frame. It is readable at bit 31 of the data register and is also brought out as a pin. While the flag is set, writes to the data word and to the mode register are dropped. Software therefore polls the flag before and after writing.

Top module: `sled_shifter`

## Requirements
- R1: After synchronous reset, every register reads zero, and `busy`, `ser_data` and `ser_clk` are low.
- R2: A data write (address 0) accepted while idle with PWM mode off raises `busy` in the cycle after the write edge. `busy` stays high for 1+17·N cycles and then falls, where N is the bit period in clock cycles.
- R3: Frame bits go out from bit 16 down to bit 0. Bit k of the frame (k=0 first) is on `ser_data` during cycles 1+k·N through (k+1)·N after the write edge. `ser_data` is low when idle.
- R4: Divider field code c (address 1, bits 1:0) sets N = 4·2^c, giving 4, 8, 16 or 32 clock cycles per bit.
- R5: Within each bit, let the bit start be cycle 0 and let d be the delay register (address 2, bits 3:0) clamped to N/2−1. With inversion off, `ser_clk` is high from cycle d+1 through cycle d+N/2 and low otherwise.
- R6: Mode bit 0 inverts `ser_clk` at all times, including its idle level.
- R7: A data write or a mode write (address 3) that arrives while `busy` is high is ignored: the readback is unchanged and no frame starts.
- R8: With PWM mode on (mode bit 1), a frame starts at the first edge where `pwm_lvl` differs from the last frame sent, and it carries `pwm_lvl` as sampled at that edge. Levels equal to the last frame, including all zeros after an all-zero frame, start nothing.
- R9: In PWM mode, an accepted data write stores the word but starts no frame.
- R10: Divider and delay writes are accepted at any time. They are sampled when a frame starts, so a change made during a frame first applies to the next frame.
- R11: Readback layout: address 0 is {busy at bit 31, data at bits 16:0}, address 1 is the divider, address 2 is the delay, address 3 is {PWM enable at bit 1, clock inversion at bit 0}. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 data, 1 divider, 2 delay, 3 mode) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register (combinational) |
| pwm_lvl | input | 17 | Live PWM channel levels, bit 16 being channel 32 |
| ser_data | output | 1 | Serial data to the external shifter |
| ser_clk | output | 1 | Shift clock to the external shifter |
| busy | output | 1 | Frame in progress or about to start |

## Verification
A direct write is sampled at edge E. `busy` is due in the cycle after E. Bit k is due from cycle 1+k·N, and its clock high phase runs from d+1 to d+N/2 cycles into each bit. `busy` falls after cycle 17·N. A PWM level change is due as a raised `busy` one cycle after the level is presented. The bench drives on the falling edge, samples on the falling edge, and indexes every cycle after the write edge against these formulas. A scoreboard collects each frame at the rising shift-clock edges and compares it with the words queued by the driver, so both unexpected frames and missing frames are reported.

// File: rtl/sled_pkg.sv
package sled_pkg;
    localparam int NCH      = 17;
    localparam int DIV_W    = 2;
    localparam int DLY_W    = 4;
    localparam int REG_W    = 32;

    typedef enum logic [1:0] {
        RA_DATA = 2'd0,
        RA_DIV  = 2'd1,
        RA_DLY  = 2'd2,
        RA_MODE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic pwm_en;   // bit 1
        logic inv_clk;  // bit 0
    } mode_t;
endpackage

// File: rtl/sled_regs.sv
module sled_regs
    import sled_pkg::*;
#(
    parameter int CH_N = NCH,
    parameter int DV_W = DIV_W,
    parameter int DL_W = DLY_W,
    parameter int RG_W = REG_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [1:0]      addr,
    input  logic [RG_W-1:0] wdata,
    input  logic            fr_busy,
    output logic [CH_N-1:0] data_q,
    output logic [DV_W-1:0] div_q,
    output logic [DL_W-1:0] dly_q,
    output mode_t           mode_q,
    output logic            go,
    output logic            busy,
    output logic [RG_W-1:0] rdata
);
    // a pending direct start counts as busy so no write slips in before the load
    assign busy = fr_busy | go;

    logic unused_wdata;
    assign unused_wdata = ^wdata[RG_W-1:CH_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            div_q  <= '0;
            dly_q  <= '0;
            mode_q <= '0;
            go     <= 1'b0;
        end else begin
            go <= 1'b0;
            if (wr) begin
                case (reg_addr_e'(addr))
                    RA_DATA: if (!busy) begin
                        data_q <= wdata[CH_N-1:0];
                        go     <= !mode_q.pwm_en;
                    end
                    RA_DIV:  div_q <= wdata[DV_W-1:0];
                    RA_DLY:  dly_q <= wdata[DL_W-1:0];
                    RA_MODE: if (!busy) mode_q <= mode_t'(wdata[1:0]);
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_addr_e'(addr))
            RA_DATA: begin
                rdata[CH_N-1:0] = data_q;
                rdata[RG_W-1]   = busy;
            end
            RA_DIV:  rdata[DV_W-1:0] = div_q;
            RA_DLY:  rdata[DL_W-1:0] = dly_q;
            RA_MODE: rdata[1:0]      = mode_q;
            default: ;
        endcase
    end
endmodule

// File: rtl/sled_bittimer.sv
module sled_bittimer
    import sled_pkg::*;
#(
    parameter int DV_W  = DIV_W,
    parameter int DL_W  = DLY_W,
    parameter int CNT_W = 1 + (1 << DV_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [DV_W-1:0]  div_code,
    input  logic [DL_W-1:0]  dly_val,
    output logic             bit_end,
    output logic             clk_hi,
    output logic [CNT_W-1:0] phase
);
    localparam int EDGE_W = CNT_W + 1;

    logic [CNT_W-1:0]  phase_q, lim_q;
    logic [EDGE_W-1:0] start_q, stop_q;
    int n_i, half_i, d_i;

    always_comb begin
        n_i    = 4 << div_code;
        half_i = n_i / 2;
        d_i    = int'(dly_val);
        if (d_i > half_i - 1) d_i = half_i - 1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            lim_q   <= '0;
            start_q <= '0;
            stop_q  <= '0;
        end else if (load) begin
            phase_q <= '0;
            lim_q   <= CNT_W'(n_i - 1);
            start_q <= EDGE_W'(d_i + 1);
            stop_q  <= EDGE_W'(d_i + 1 + half_i);
        end else if (run) begin
            phase_q <= bit_end ? '0 : phase_q + 1'b1;
        end else begin
            phase_q <= '0;
        end
    end

    assign bit_end = run && (phase_q == lim_q);
    assign clk_hi  = run && (EDGE_W'(phase_q) >= start_q) && (EDGE_W'(phase_q) < stop_q);
    assign phase   = phase_q;
endmodule

// File: rtl/sled_framer.sv
module sled_framer
    import sled_pkg::*;
#(
    parameter int CH_N = NCH
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    input  logic            pwm_en,
    input  logic [CH_N-1:0] data_word,
    input  logic [CH_N-1:0] pwm_lvl,
    input  logic            bit_end,
    output logic            fr_busy,
    output logic            load,
    output logic            ser_bit,
    output logic [CH_N-1:0] last_word
);
    localparam int IDX_W = $clog2(CH_N);

    logic [CH_N-1:0]  shreg;
    logic [IDX_W-1:0] idx;
    logic             pwm_req;
    logic [CH_N-1:0]  src;

    assign pwm_req = pwm_en && (pwm_lvl != last_word);
    assign load    = !fr_busy && (go || pwm_req);
    assign src     = go ? data_word : pwm_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            fr_busy   <= 1'b0;
            shreg     <= '0;
            idx       <= '0;
            last_word <= '0;
        end else if (load) begin
            fr_busy   <= 1'b1;
            shreg     <= src;
            idx       <= '0;
            last_word <= src;
        end else if (fr_busy && bit_end) begin
            if (idx == IDX_W'(CH_N - 1)) begin
                fr_busy <= 1'b0;
                shreg   <= '0;
                idx     <= '0;
            end else begin
                idx   <= idx + 1'b1;
                shreg <= {shreg[CH_N-2:0], 1'b0};
            end
        end
    end

    assign ser_bit = fr_busy & shreg[CH_N-1];
endmodule

// File: rtl/sled_shifter.sv
module sled_shifter
    import sled_pkg::*;
#(
    parameter int CH_N = NCH,
    parameter int DV_W = DIV_W,
    parameter int DL_W = DLY_W,
    parameter int RG_W = REG_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_wr,
    input  logic [1:0]      reg_addr,
    input  logic [RG_W-1:0] reg_wdata,
    output logic [RG_W-1:0] reg_rdata,
    input  logic [CH_N-1:0] pwm_lvl,
    output logic            ser_data,
    output logic            ser_clk,
    output logic            busy
);
    localparam int CNT_W = 1 + (1 << DV_W);

    logic [CH_N-1:0]  data_word, last_word;
    logic [DV_W-1:0]  div_code;
    logic [DL_W-1:0]  dly_val;
    mode_t            mode_q;
    logic             go, fr_busy, load, bit_end, clk_hi;
    logic [CNT_W-1:0] bit_phase;

    sled_regs #(.CH_N(CH_N), .DV_W(DV_W), .DL_W(DL_W), .RG_W(RG_W)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .fr_busy(fr_busy), .data_q(data_word), .div_q(div_code), .dly_q(dly_val),
        .mode_q(mode_q), .go(go), .busy(busy), .rdata(reg_rdata)
    );

    sled_bittimer #(.DV_W(DV_W), .DL_W(DL_W), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(load), .run(fr_busy), .div_code(div_code),
        .dly_val(dly_val), .bit_end(bit_end), .clk_hi(clk_hi), .phase(bit_phase)
    );

    sled_framer #(.CH_N(CH_N)) u_framer (
        .clk(clk), .rst(rst), .go(go), .pwm_en(mode_q.pwm_en), .data_word(data_word),
        .pwm_lvl(pwm_lvl), .bit_end(bit_end), .fr_busy(fr_busy), .load(load),
        .ser_bit(ser_data), .last_word(last_word)
    );

    assign ser_clk = clk_hi ^ mode_q.inv_clk;
endmodule

// File: rtl/sled_chk.sv
module sled_chk
    import sled_pkg::*;
#(
    parameter int CH_N  = NCH,
    parameter int CNT_W = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            reg_wr,
    input logic [1:0]      reg_addr,
    input logic            busy,
    input logic            fr_busy,
    input logic            ser_data,
    input logic            ser_clk,
    input logic [CH_N-1:0] data_word,
    input logic [CH_N-1:0] last_word,
    input logic [CH_N-1:0] pwm_lvl,
    input mode_t           mode_q,
    input logic [CNT_W-1:0] bit_phase
);
    AST_DIRECT_START: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd0 && !busy && !mode_q.pwm_en) |=> busy); // R2

    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fr_busy && bit_phase != '0) |-> $stable(ser_data)); // R3

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
        (!busy) |-> (!ser_data && ser_clk == mode_q.inv_clk)); // R6

    AST_DATA_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_wr && reg_addr == 2'd0) |=> $stable(data_word)); // R7

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_wr && reg_addr == 2'd3) |=> $stable(mode_q)); // R7

    AST_PWM_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (mode_q.pwm_en && !busy && pwm_lvl != last_word) |=> fr_busy); // R8
endmodule

bind sled_shifter sled_chk #(.CH_N(CH_N), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .busy(busy),
    .fr_busy(fr_busy), .ser_data(ser_data), .ser_clk(ser_clk), .data_word(data_word),
    .last_word(last_word), .pwm_lvl(pwm_lvl), .mode_q(mode_q), .bit_phase(bit_phase)
);

// File: tb/sim_sled_shifter.sv
`timescale 1ns/1ps
module sim_sled_shifter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [16:0] pwm_lvl = '0;
    logic        ser_data, ser_clk, busy;

    int nchk = 0;
    int nfail = 0;
    logic type_tb = 1'b0;
    logic [16:0] expq[$];

    always #2 clk = ~clk;

    sled_shifter u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_lvl(pwm_lvl),
        .ser_data(ser_data), .ser_clk(ser_clk), .busy(busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a; #1;
        v = reg_rdata;
    endtask

    task automatic mode_wr(input logic inv, input logic pwm);
        wr(2'd3, {30'd0, pwm, inv});
        type_tb = inv;
    endtask

    task automatic send_direct(input logic [16:0] w);
        expq.push_back(w);
        wr(2'd0, {15'd0, w});
    endtask

    task automatic wait_idle();
        int quiet = 0;
        for (int i = 0; i < 5000 && quiet < 3; i++) begin
            @(negedge clk);
            quiet = busy ? 0 : quiet + 1;
        end
    endtask

    task automatic quiet_check(input string tag, input int cycles);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (busy) seen++;
        end
        chk(tag, seen, 0);
    endtask

    // per-cycle timing sweep starting in the cycle after the write edge
    task automatic sweep(input logic [16:0] w, input int code, input int dly,
                         input logic inv, input bit midwr, input string clktag);
        int n = 4 << code;
        int half = n / 2;
        int de = (dly > half - 1) ? half - 1 : dly;
        int eb = 0, ed = 0, ec = 0;
        logic xb, xd, xc;
        for (int j = 0; j <= 17 * n + 2; j++) begin
            @(negedge clk);
            xb = (j <= 17 * n);
            if (j >= 1 && j <= 17 * n) begin
                xd = w[16 - (j - 1) / n];
                xc = (((j - 1) % n) >= de + 1) && (((j - 1) % n) < de + 1 + half);
            end else begin
                xd = 1'b0; xc = 1'b0;
            end
            xc = xc ^ inv;
            if (busy !== xb) begin if (eb == 0) $display("  busy mismatch at cycle %0d", j); eb++; end
            if (ser_data !== xd) begin if (ed == 0) $display("  data mismatch at cycle %0d", j); ed++; end
            if (ser_clk !== xc) begin if (ec == 0) $display("  clock mismatch at cycle %0d", j); ec++; end
            if (midwr && j == 5) begin reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = code + 1; end
            if (midwr && j == 6) reg_wr = 1'b0;
        end
        chk("R2 busy window mismatches", eb, 0);
        chk("R3 R4 serial data mismatches", ed, 0);
        chk({clktag, " shift clock mismatches"}, ec, 0);
    endtask

    // scoreboard monitor: collect a frame at rising shift-clock edges
    logic prev_eff = 1'b0;
    logic [16:0] cap = '0;
    int nbits = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if ((ser_clk ^ type_tb) && !prev_eff) begin
                cap = {cap[15:0], ser_data};
                nbits++;
                if (nbits == 17) begin
                    nbits = 0;
                    if (expq.size() == 0) begin
                        nchk++; nfail++;
                        $display("FAIL R8 unexpected frame actual=%h expected=none", cap);
                    end else begin
                        chk("R3 R8 frame content", {15'd0, cap}, {15'd0, expq.pop_front()});
                    end
                end
            end
            prev_eff = ser_clk ^ type_tb;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (5) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            chk("R1 register reset", v, 32'd0);
        end
        chk("R1 idle lines", {29'd0, busy, ser_data, ser_clk}, 32'd0);

        // R11 readback map
        wr(2'd1, 32'hFFFF_FFFE); rd(2'd1, v); chk("R11 divider readback", v, 32'd2);
        wr(2'd2, 32'hFFFF_FFF3); rd(2'd2, v); chk("R11 delay readback", v, 32'd3);
        mode_wr(1'b1, 1'b0);     rd(2'd3, v); chk("R11 mode readback", v, 32'd1);
        @(negedge clk); chk("R6 idle clock inverted", {31'd0, ser_clk}, 32'd1);
        mode_wr(1'b0, 1'b0);

        // R2 R3 R4 R5 timing sweeps
        wr(2'd1, 0); wr(2'd2, 0);
        send_direct(17'h1A5C3); rd(2'd0, v);
        chk("R11 data readback with busy", v, 32'h8001_A5C3);
        wait_idle();
        send_direct(17'h1A5C3); sweep(17'h1A5C3, 0, 0, 1'b0, 1'b0, "R5");
        wr(2'd1, 1); wr(2'd2, 2);
        send_direct(17'h0F0F1); sweep(17'h0F0F1, 1, 2, 1'b0, 1'b0, "R5");
        wr(2'd1, 3); wr(2'd2, 15);
        send_direct(17'h10001); sweep(17'h10001, 3, 15, 1'b0, 1'b0, "R5");
        wr(2'd1, 0); wr(2'd2, 5);
        send_direct(17'h15555); sweep(17'h15555, 0, 5, 1'b0, 1'b0, "R5 clamp");

        // R6 inverted clock
        mode_wr(1'b1, 1'b0); wr(2'd1, 2); wr(2'd2, 3);
        send_direct(17'h0AAAA); sweep(17'h0AAAA, 2, 3, 1'b1, 1'b0, "R6");
        mode_wr(1'b0, 1'b0);

        // R7 writes ignored while busy
        wr(2'd1, 0); wr(2'd2, 1);
        send_direct(17'h1F00F);
        repeat (10) @(negedge clk);
        wr(2'd0, 32'h0000_0FF0);
        wr(2'd3, 32'd3);
        wait_idle();
        rd(2'd0, v); chk("R7 data kept", v, 32'h0001_F00F);
        rd(2'd3, v); chk("R7 mode kept", v, 32'd0);
        quiet_check("R7 no extra frame", 30);

        // R10 divider change during a frame applies next frame
        send_direct(17'h13579); sweep(17'h13579, 0, 1, 1'b0, 1'b1, "R10");
        rd(2'd1, v); chk("R10 divider accepted while busy", v, 32'd1);
        send_direct(17'h02468); sweep(17'h02468, 1, 1, 1'b0, 1'b0, "R10");

        // R8 PWM mode: clear the shifter, then follow level changes
        send_direct(17'h00000); wait_idle();
        mode_wr(1'b0, 1'b1);
        quiet_check("R8 zero levels start nothing", 40);
        expq.push_back(17'h10001);
        @(negedge clk); pwm_lvl = 17'h10001;
        @(negedge clk); chk("R8 busy one cycle after change", {31'd0, busy}, 32'd1);
        repeat (10) @(negedge clk);
        expq.push_back(17'h00100);
        pwm_lvl = 17'h00100;
        wait_idle();
        quiet_check("R8 unchanged levels start nothing", 40);

        // R9 data write in PWM mode
        wr(2'd0, 32'h0000_ABCD);
        quiet_check("R9 no frame from data write", 30);
        rd(2'd0, v); chk("R9 data stored", v, 32'h0000_ABCD);

        expq.push_back(17'h00000);
        @(negedge clk); pwm_lvl = 17'h00000;
        wait_idle();
        chk("R8 scoreboard drained", expq.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule